// File: doc/BRIEF.md
# Content-Addressable Word Store

This block is a small array of fixed-width words. It can be used like an ordinary RAM through an addressed write port and an addressed read port. It can also be asked, through a search port, which of its words hold a given key. A search compares the key with every word in the same cycle and returns one hit bit per word, plus a single flag that is raised when no word hits.

Each word carries a presence bit. Writing a word sets its presence bit. After reset, no word is present, and a word that is not present never hits. While a search is being evaluated, no word can be addressed. For this reason a search waits for any cycle that carries a read or a write.

The search request is a valid/ready stream. The requester raises `find_valid` with `find_key` and must hold both unchanged until it sees `find_ready` high at a rising edge. `find_ready` is low in every cycle in which `wr_en` or `rd_en` is high. The result has no back-pressure. `hit_valid` pulses for exactly one cycle, and `hit_vec` and `none_hit` keep their values until the next result.

Top module: `cam_store`

## Requirements
- R1: A write of data D to address A, followed by a read of A, returns D on `rd_data` one clock after the read is requested. `rd_data` keeps its value in cycles without `rd_en`.
- R2: A read and a write to the same address in the same cycle return the contents the word held before that write.
- R3: After reset, `rd_data` is zero, `hit_valid` is low, `none_hit` is high and `hit_vec` is zero. Until a word is written, a search for any key, including all zeros, reports no hit for that word.
- R4: In a search result, bit i of `hit_vec` is 1 exactly when word i has been written and its stored data equals the key. All such words are reported together.
- R5: `none_hit` is 1 exactly when every bit of `hit_vec` is 0.
- R6: `hit_valid` is high for exactly the one cycle after a search is accepted (`find_valid` and `find_ready` both high at a rising edge). `hit_vec` and `none_hit` do not change in any other cycle.
- R7: `find_ready` is low in any cycle where `wr_en` or `rd_en` is high, and high otherwise. A search waiting on such a cycle is accepted in the first cycle free of accesses.
- R8: A search accepted in the cycle after a write sees the newly written data.
- R9: Overwriting a word replaces its data. A search for its previous value no longer reports that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | $clog2(WORDS) | Word written |
| wr_data | input | WIDTH | Data written |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(WORDS) | Word read |
| rd_data | output | WIDTH | Read data, registered |
| find_valid | input | 1 | Search request valid |
| find_ready | output | 1 | Search request accepted when high with valid |
| find_key | input | WIDTH | Key compared with all words |
| hit_valid | output | 1 | One-cycle pulse marking a new result |
| hit_vec | output | WORDS | Per-word hit bits |
| none_hit | output | 1 | High when no word hits |

## Verification
The bench builds the store with 8 words of 4 bits. With these values it can fill every word, find the same key in several words at once, and search for a value that no word holds. The narrow key also makes an all-zero key against freshly reset words a natural test. It checks searches that collide with writes and with reads, a search issued directly behind a write, and a read and write to the same word in the same cycle.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // Which kind of operation owns the array in a given cycle.
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_ACCESS = 2'd1,
    SLOT_SEARCH = 2'd2
  } cam_slot_e;
endpackage

// File: rtl/cam_arb.sv
module cam_arb
  import cam_pkg::*;
(
  input  logic wr_en,
  input  logic rd_en,
  input  logic find_valid,
  output logic find_ready,
  output logic search_go
);
  cam_slot_e slot;

  // Addressed accesses own the array; a search only gets a free cycle.
  always_comb begin
    if (wr_en || rd_en)   slot = SLOT_ACCESS;
    else if (find_valid)  slot = SLOT_SEARCH;
    else                  slot = SLOT_IDLE;
  end

  assign find_ready = (slot != SLOT_ACCESS);
  assign search_go  = (slot == SLOT_SEARCH);
endmodule

// File: rtl/cam_entry.sv
module cam_entry #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic [WIDTH-1:0] key,
  output logic [WIDTH-1:0] word,
  output logic             line_hit
);
  logic present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      present <= 1'b0;
    end else if (load) begin
      word    <= load_data;
      present <= 1'b1;
    end
  end

  // Line starts at "hit"; any differing bit, or an empty word, clears it.
  always_comb begin
    line_hit = 1'b1;
    if (!present) line_hit = 1'b0;
    for (int b = 0; b < WIDTH; b++) begin
      if (word[b] != key[b]) line_hit = 1'b0;
    end
  end
endmodule

// File: rtl/cam_result.sv
module cam_result #(
  parameter int WORDS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WORDS-1:0] lines,
  output logic             hit_valid,
  output logic [WORDS-1:0] hit_vec,
  output logic             none_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_vec   <= '0;
      none_hit  <= 1'b1;
    end else begin
      hit_valid <= capture;
      if (capture) begin
        hit_vec  <= lines;
        none_hit <= ~|lines;
      end
    end
  end
endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int WORDS = 16,
  parameter int WIDTH = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             find_valid,
  output logic             find_ready,
  input  logic [WIDTH-1:0] find_key,
  output logic             hit_valid,
  output logic [WORDS-1:0] hit_vec,
  output logic             none_hit
);
  logic             search_go;
  logic [WORDS-1:0] lines;
  logic [WIDTH-1:0] words [WORDS];

  cam_arb u_arb (
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .find_valid (find_valid),
    .find_ready (find_ready),
    .search_go  (search_go)
  );

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    cam_entry #(.WIDTH(WIDTH)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_en && (wr_addr == AW'(i))),
      .load_data (wr_data),
      .key       (find_key),
      .word      (words[i]),
      .line_hit  (lines[i])
    );
  end

  // Registered read of the pre-write contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= words[rd_addr];
  end

  cam_result #(.WORDS(WORDS)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (search_go),
    .lines     (lines),
    .hit_valid (hit_valid),
    .hit_vec   (hit_vec),
    .none_hit  (none_hit)
  );
endmodule

// File: rtl/cam_store_checker.sv
module cam_store_checker #(
  parameter int WORDS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             find_valid,
  input logic             find_ready,
  input logic             hit_valid,
  input logic [WORDS-1:0] hit_vec,
  input logic             none_hit
);
  assert_none_is_nor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    none_hit == (hit_vec == '0));

  assert_pulse_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (find_valid && find_ready) |=> hit_valid);

  assert_no_stray_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(find_valid && find_ready) |=> !hit_valid);

  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(find_valid && find_ready) |=> ($stable(hit_vec) && $stable(none_hit)));

  assert_access_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> !find_ready);

  assert_free_cycle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |-> find_ready);
endmodule

bind cam_store cam_store_checker #(.WORDS(WORDS)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .find_valid (find_valid),
  .find_ready (find_ready),
  .hit_valid  (hit_valid),
  .hit_vec    (hit_vec),
  .none_hit   (none_hit)
);

// File: tb/test_cam_store.sv
module test_cam_store;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 8;
  localparam int WIDTH = 4;
  localparam int AW = 3;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, find_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [WIDTH-1:0] wr_data = '0, find_key = '0;
  logic [WIDTH-1:0] rd_data;
  logic find_ready, hit_valid, none_hit;
  logic [WORDS-1:0] hit_vec;

  logic [WIDTH-1:0] m_data [WORDS];
  logic [WORDS-1:0] m_present = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) i_cam_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .find_valid(find_valid), .find_ready(find_ready), .find_key(find_key),
    .hit_valid(hit_valid), .hit_vec(hit_vec), .none_hit(none_hit)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORDS-1:0] expect_hits(input logic [WIDTH-1:0] k);
    logic [WORDS-1:0] v = '0;
    for (int i = 0; i < WORDS; i++) v[i] = m_present[i] && (m_data[i] == k);
    return v;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_data[a] = d; m_present[a] = 1'b1;
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, "read data", 32'(rd_data), 32'(m_data[a]));
  endtask

  // Search in a free cycle; checks pulse, hits, miss and hold afterwards.
  task automatic do_search(input string req, input logic [WIDTH-1:0] k);
    logic [WORDS-1:0] e;
    e = expect_hits(k);
    @(negedge clk);
    find_valid = 1'b1; find_key = k;
    #1 check("R7", "ready in free cycle", 32'(find_ready), 32'd1);
    @(negedge clk);
    find_valid = 1'b0;
    check("R6", "result pulse", 32'(hit_valid), 32'd1);
    check(req, "hit vector", 32'(hit_vec), 32'(e));
    check("R5", "none flag", 32'(none_hit), 32'(e == '0));
    @(negedge clk);
    check("R6", "pulse ends", 32'(hit_valid), 32'd0);
    check("R6", "vector held", 32'(hit_vec), 32'(e));
  endtask

  task automatic t_reset;
    check("R3", "rd_data reset", 32'(rd_data), 32'd0);
    check("R3", "hit_valid reset", 32'(hit_valid), 32'd0);
    check("R3", "none_hit reset", 32'(none_hit), 32'd1);
    check("R3", "hit_vec reset", 32'(hit_vec), 32'd0);
    do_search("R3", 4'h0);
    check("R3", "empty words miss key 0", 32'(none_hit), 32'd1);
  endtask

  task automatic t_fill_and_read;
    for (int i = 0; i < WORDS; i++) do_write(AW'(i), WIDTH'(i + 3));
    for (int i = 0; i < WORDS; i++) do_read("R1", AW'(i));
    @(negedge clk);
    check("R1", "read data held", 32'(rd_data), 32'(m_data[WORDS-1]));
  endtask

  task automatic t_multi_hit;
    do_write(3'd2, 4'hA);
    do_write(3'd5, 4'hA);
    do_search("R4", 4'hA);
    check("R5", "none low on hits", 32'(none_hit), 32'd0);
    do_search("R4", 4'h3);
  endtask

  task automatic t_absent_key;
    do_search("R5", 4'hF);
    check("R5", "absent key miss", 32'(none_hit), 32'd1);
  endtask

  task automatic t_read_write_same;
    logic [WIDTH-1:0] old;
    old = m_data[3];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 4'hC;
    rd_en = 1'b1; rd_addr = 3'd3;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    m_data[3] = 4'hC;
    check("R2", "same-cycle read gives old", 32'(rd_data), 32'(old));
    do_read("R1", 3'd3);
  endtask

  task automatic t_overwrite;
    logic [WIDTH-1:0] old;
    old = m_data[6];
    do_write(3'd6, 4'h1);
    do_search("R9", old);
    check("R9", "old value gone from word 6", 32'(hit_vec[6]), 32'd0);
    do_search("R9", 4'h1);
  endtask

  task automatic t_write_holdoff;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 4'hE;
    find_valid = 1'b1; find_key = 4'hE;
    #1 check("R7", "ready low with write", 32'(find_ready), 32'd0);
    @(negedge clk);
    wr_en = 1'b0;
    m_data[7] = 4'hE; m_present[7] = 1'b1;
    check("R7", "no result while held", 32'(hit_valid), 32'd0);
    #1 check("R7", "ready after write", 32'(find_ready), 32'd1);
    @(negedge clk);
    find_valid = 1'b0;
    check("R7", "held search done", 32'(hit_valid), 32'd1);
    check("R8", "sees fresh write", 32'(hit_vec), 32'(expect_hits(4'hE)));
  endtask

  task automatic t_read_holdoff;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd2;
    find_valid = 1'b1; find_key = 4'hA;
    #1 check("R7", "ready low with read", 32'(find_ready), 32'd0);
    @(negedge clk);
    rd_en = 1'b0;
    check("R7", "no result during read", 32'(hit_valid), 32'd0);
    check("R1", "read alongside search", 32'(rd_data), 32'(m_data[2]));
    @(negedge clk);
    find_valid = 1'b0;
    check("R7", "search after read", 32'(hit_valid), 32'd1);
    check("R4", "hits after read", 32'(hit_vec), 32'(expect_hits(4'hA)));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) m_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_read();
    t_multi_hit();
    t_absent_key();
    t_read_write_same();
    t_overwrite();
    t_write_holdoff();
    t_read_holdoff();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL all watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule